// File: doc/BRIEF.md
# CPU Clock Mode Controller

This block decides which clock drives the processor and every function block behind it. It can pass the raw oscillator clock straight through (slow mode), or it can use an external multiplier clock that is divided by two (normal mode). The multiplier is assumed to run at twelve times the oscillator, so a 4 MHz crystal gives a 24 MHz system clock in normal mode. Software controls the block through one mode register on a simple register bus. The register runs in the oscillator domain and can be read back.

The block always comes out of reset in slow mode, with the multiplier disabled. Software reaches normal mode in two writes. The first write clears bit 1 of the mode field. This enters an idle step, which enables the multiplier and waits for its lock indication. The second write, once lock is seen, clears the whole mode field. The changeover itself is a two-sided enable handshake. Each source is switched off while its own clock is low, and the other source is switched on only after that, so the output never carries a runt pulse. A slow-mode status output lets dependent logic, such as a display engine or PWM timing, be gated or reconfigured.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the mode register reads 0x0023: field bits 3:0 = 4'b0011 (slow), bit 4 busy = 0, bit 5 oscillator-source = 1. In this state slow_mode = 1, pll_en = 0, and clk_sys follows osc_clk.
- R2: The register answers only at bus address 0xFC00. A read at any other address returns 0, and bits 15:6 always read 0.
- R3: In slow mode, a write whose bits 3:0 are 4'b0001 enters the idle step. Bits 15:4 of the write are ignored. In the idle step the field reads 4'b0001, pll_en = 1, and the system clock is still the oscillator.
- R4: In slow mode, a write with bits 3:0 = 0 (idle step skipped) is ignored. The register still reads 0x0023 and pll_en stays 0.
- R5: In the idle step, while the synchronised pll_lock is 0, busy reads 1 and a write of 0 to bits 3:0 is ignored.
- R6: In the idle step with lock seen, a write of 0 to bits 3:0 switches to normal mode. When the switch is done, the register reads 0x0000, slow_mode = 0, and clk_sys runs at half the pll_clk rate.
- R7: No high or low phase on clk_sys is shorter than half a period of the faster selected source. Both sources are never enabled at the same time.
- R8: In normal mode, a write with nonzero bits 3:0 returns the block to slow mode through the same changeover. The register then reads 0x0023, pll_en = 0, and clk_sys runs at the osc_clk rate.
- R9: In the idle step, a write with bit 1 set returns the block straight to slow mode and disables the multiplier.
- R10: Writes made while a changeover is in progress (busy = 1 after the normal-mode request) are ignored, and the changeover completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; also the register-bus clock |
| pll_clk | input | 1 | Multiplier output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock | input | 1 | Multiplier lock indication (asynchronous) |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when the register is not addressed |
| clk_sys | output | 1 | Selected system clock |
| slow_mode | output | 1 | 1 while the oscillator drives clk_sys |
| pll_en | output | 1 | Enable for the external multiplier |

## Verification
The assertions assume that the bus is driven only in the oscillator domain, and that pll_clk and pll_lock keep toggling or holding steady on their own, with pll_lock never dropping once the block is in normal mode. The stimulus changes bus signals only on falling oscillator edges. It raises the lock input only after the multiplier enable is seen, and it keeps the lock high until the block is back in slow mode. Runt pulses are caught by timing every edge of clk_sys across the whole run.

// File: rtl/clkmode_ctrl.sv
`timescale 1ns/1ps
module clkmode_ctrl #(
  parameter int              AW        = 16,
  parameter int              DW        = 16,
  parameter logic [AW-1:0]   MODE_ADDR = 16'hFC00,
  parameter int              SYNC_N    = 2
) (
  input  logic          osc_clk,
  input  logic          pll_clk,
  input  logic          rst_n,
  input  logic          pll_lock,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          clk_sys,
  output logic          slow_mode,
  output logic          pll_en
);
  localparam logic [3:0] CODE_SLOW = 4'b0011;
  localparam logic [3:0] CODE_IDLE = 4'b0001;
  localparam logic [3:0] CODE_NORM = 4'b0000;

  typedef enum logic [2:0] {
    S_SLOW = 3'd0, S_IDLE = 3'd1, S_TO_NORM = 3'd2, S_NORM = 3'd3, S_TO_SLOW = 3'd4
  } mode_st_t;

  mode_st_t           st;
  logic [SYNC_N-1:0]  lock_q, ack_q, fast_q;
  logic               lock_s, fast_ack, req_fast;
  logic               div_clk, en_fast, en_slow, busy;
  logic               hit, wr_hit;
  logic [3:0]         wcode, code;
  logic               unused_wdata;

  assign hit          = bus_sel && (bus_addr == MODE_ADDR);
  assign wr_hit       = hit && bus_wr;
  assign wcode        = bus_wdata[3:0];
  assign unused_wdata = ^bus_wdata[DW-1:4];
  assign lock_s       = lock_q[SYNC_N-1];
  assign fast_ack     = ack_q[SYNC_N-1];
  assign req_fast     = (st == S_TO_NORM) || (st == S_NORM);

  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n) begin
      lock_q <= '0;
      ack_q  <= '0;
    end else begin
      lock_q <= {lock_q[SYNC_N-2:0], pll_lock};
      ack_q  <= {ack_q[SYNC_N-2:0], en_fast};
    end

  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n) st <= S_SLOW;
    else begin
      case (st)
        S_SLOW:    if (wr_hit && wcode == CODE_IDLE) st <= S_IDLE;
        S_IDLE:    if (wr_hit) begin
                     if (wcode == CODE_NORM && lock_s) st <= S_TO_NORM;
                     else if (wcode[1])                st <= S_SLOW;
                   end
        S_TO_NORM: if (fast_ack) st <= S_NORM;
        S_NORM:    if (wr_hit && wcode != CODE_NORM) st <= S_TO_SLOW;
        S_TO_SLOW: if (en_slow) st <= S_SLOW;
        default:   st <= S_SLOW;
      endcase
    end

  always_ff @(posedge pll_clk or negedge rst_n)
    if (!rst_n) div_clk <= 1'b0;
    else        div_clk <= ~div_clk;

  always_ff @(posedge div_clk or negedge rst_n)
    if (!rst_n) fast_q <= '0;
    else        fast_q <= {fast_q[SYNC_N-2:0], req_fast & ~en_slow};

  always_ff @(negedge div_clk or negedge rst_n)
    if (!rst_n) en_fast <= 1'b0;
    else        en_fast <= fast_q[SYNC_N-1];

  always_ff @(negedge osc_clk or negedge rst_n)
    if (!rst_n) en_slow <= 1'b1;
    else        en_slow <= ~req_fast & ~fast_ack;

  assign clk_sys   = (osc_clk & en_slow) | (div_clk & en_fast);
  assign slow_mode = en_slow;
  assign pll_en    = (st != S_SLOW);
  assign busy      = (st == S_IDLE && !lock_s) || st == S_TO_NORM || st == S_TO_SLOW;

  always_comb begin
    case (st)
      S_IDLE:          code = CODE_IDLE;
      S_TO_NORM, S_NORM: code = CODE_NORM;
      default:         code = CODE_SLOW;
    endcase
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[3:0] = code;
      bus_rdata[4]   = busy;
      bus_rdata[5]   = en_slow;
    end
  end
endmodule

// File: rtl/clkmode_ctrl_chk.sv
`timescale 1ns/1ps
module clkmode_ctrl_chk #(
  parameter logic [15:0] MODE_ADDR = 16'hFC00
) (
  input logic        osc_clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [15:0] bus_addr,
  input logic [15:0] bus_wdata,
  input logic        slow_mode,
  input logic        pll_en,
  input logic [2:0]  st,
  input logic        en_fast,
  input logic        req_fast,
  input logic        lock_s
);
  logic wr;
  assign wr = bus_sel && bus_wr && (bus_addr == MODE_ADDR);

  a_r1_slow_pll_off: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == 3'd0) |-> (!pll_en && slow_mode));

  a_r3_idle_pll_on: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == 3'd1) |-> (pll_en && slow_mode));

  a_r4_no_skip: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == 3'd0 && wr && bus_wdata[3:0] == 4'h0) |=> (st == 3'd0 && !pll_en));

  a_r6_lock_first: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(req_fast) |-> lock_s);

  a_r7_exclusive: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !(slow_mode && en_fast));

  a_r8_leave_normal: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == 3'd3 && wr && bus_wdata[3:0] != 4'h0) |=> !req_fast);

  a_r10_busy_ignore: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == 3'd2 && wr) |=> (st == 3'd2 || st == 3'd3));
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .osc_clk(osc_clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .slow_mode(slow_mode),
  .pll_en(pll_en), .st(st), .en_fast(en_fast), .req_fast(req_fast),
  .lock_s(lock_s)
);

// File: tb/clkmode_ctrl_tb.sv
`timescale 1ns/1ps
module clkmode_ctrl_tb;
  logic osc_clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0, pll_lock = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic clk_sys, slow_mode, pll_en;

  int checks = 0, fails = 0, glitches = 0, rises = 0;
  bit mon_en = 1'b0;
  realtime last_t = 0;

  always #4 osc_clk = ~osc_clk;
  always #0.333 pll_clk = ~pll_clk;

  clkmode_ctrl u_dut (
    .osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n), .pll_lock(pll_lock),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .clk_sys(clk_sys), .slow_mode(slow_mode), .pll_en(pll_en)
  );

  always @(posedge clk_sys) rises++;
  always @(clk_sys) begin
    if (mon_en && ($realtime - last_t) < 0.6) glitches++;
    last_t = $realtime;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_range(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [15:0] d);
    @(negedge osc_clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge osc_clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [15:0] d);
    @(negedge osc_clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_not_busy();
    logic [15:0] d;
    for (int i = 0; i < 40; i++) begin
      bus_read(16'hFC00, d);
      if (!d[4]) break;
    end
  endtask

  task automatic count_rises(output int n);
    int s;
    s = rises;
    #80;
    n = rises - s;
  endtask

  task automatic t_reset();
    logic [15:0] d; int n;
    bus_read(16'hFC00, d);
    chk("R1 reset readback", d, 16'h0023);
    chk("R1 slow_mode", slow_mode, 1);
    chk("R1 pll_en", pll_en, 0);
    count_rises(n);
    chk_range("R1 osc rate edges", n, 9, 11);
  endtask

  task automatic t_address();
    logic [15:0] d;
    bus_read(16'h1234, d);
    chk("R2 other address", d, 16'h0000);
    bus_read(16'hFC01, d);
    chk("R2 neighbour address", d, 16'h0000);
  endtask

  task automatic t_skip_idle();
    logic [15:0] d;
    bus_write(16'hFC00, 16'h0000);
    bus_read(16'hFC00, d);
    chk("R4 skip ignored", d, 16'h0023);
    chk("R4 pll stays off", pll_en, 0);
  endtask

  task automatic t_enter_idle();
    logic [15:0] d;
    bus_write(16'hFC00, 16'hFFF1);
    bus_read(16'hFC00, d);
    chk("R3 idle readback (busy)", d, 16'h0031);
    chk("R3 pll_en", pll_en, 1);
    chk("R3 still slow", slow_mode, 1);
  endtask

  task automatic t_no_lock();
    logic [15:0] d;
    bus_write(16'hFC00, 16'h0000);
    bus_read(16'hFC00, d);
    chk("R5 write without lock ignored", d, 16'h0031);
    chk("R5 still slow", slow_mode, 1);
  endtask

  task automatic t_idle_back();
    logic [15:0] d;
    bus_write(16'hFC00, 16'h0002);
    bus_read(16'hFC00, d);
    chk("R9 back to slow", d, 16'h0023);
    chk("R9 pll off", pll_en, 0);
  endtask

  task automatic t_to_normal();
    logic [15:0] d; int n;
    bus_write(16'hFC00, 16'h0001);
    pll_lock = 1'b1;
    repeat (4) @(negedge osc_clk);
    bus_read(16'hFC00, d);
    chk("R5 lock seen clears busy", d, 16'h0021);
    bus_write(16'hFC00, 16'h0000);
    bus_write(16'hFC00, 16'h0003);
    wait_not_busy();
    bus_read(16'hFC00, d);
    chk("R6/R10 normal readback", d, 16'h0000);
    chk("R6 slow_mode low", slow_mode, 0);
    chk("R6 pll_en", pll_en, 1);
    count_rises(n);
    chk_range("R6 divided rate edges", n, 56, 64);
    chk("R7 no runt into normal", glitches, 0);
  endtask

  task automatic t_to_slow();
    logic [15:0] d; int n;
    bus_write(16'hFC00, 16'h0005);
    wait_not_busy();
    bus_read(16'hFC00, d);
    chk("R8 back to slow readback", d, 16'h0023);
    chk("R8 pll off", pll_en, 0);
    chk("R8 slow_mode", slow_mode, 1);
    count_rises(n);
    chk_range("R8 osc rate edges", n, 9, 11);
    chk("R7 no runt back to slow", glitches, 0);
    pll_lock = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge osc_clk);
    rst_n = 1'b1;
    @(negedge osc_clk);
    mon_en = 1'b1;
    t_reset();
    t_address();
    t_skip_idle();
    t_enter_idle();
    t_no_lock();
    t_idle_back();
    t_to_normal();
    t_to_slow();
    t_to_normal();
    t_to_slow();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule